// File: doc/BRIEF.md
# Flash Program-Start Qualifier

This block sits between the write-control strobes a host drives toward an embedded flash (active-low chip select `ce_n`, output enable `oe_n` and write enable `we_n`) and the single-cycle request that starts an internal program cycle in the array. A program start reaches the array only when several conditions all hold. The supply comparator must report a good level. A lockout timer must have run its full length since that level last appeared. The strobes must be in the write combination, and that combination must have lasted long enough to rule out a glitch.

The block also holds a one-bit special programming mode. An already-decoded command pulse sets it. It is cleared when the supply goes away, or when a dedicated active-low exit pin is held low for a minimum number of cycles and then released. Every asynchronous pin passes through a two-flop synchronizer. All delays and widths are parameters counted in `clk` cycles. There is no data stream, so every pin is a plain level or a single-cycle pulse.

Top module: `flash_prog_guard`

## Requirements
- R1: While `rst_n` is low and right after it is released, `prog_start`, `prog_mode` and `supply_ready` are all 0.
- R2: After `supply_ok` goes high and stays high, `supply_ready` is 0 for POR_DELAY+1 rising edges and is 1 from edge POR_DELAY+2 onward. This count includes the two synchronizer stages.
- R3: When `supply_ok` goes low, even for two cycles, `supply_ready` drops and the lockout count restarts from zero. `supply_ready` then needs the full R2 delay again after `supply_ok` returns high.
- R4: `prog_start` never pulses while `supply_ready` is 0. This covers a supply that is off and a supply that is still in its lockout delay.
- R5: Each of these on its own prevents a program start: `oe_n` low, `ce_n` high, or `we_n` high.
- R6: The write combination is `ce_n`=0, `we_n`=0 and `oe_n`=1. If it holds for fewer than GLITCH_W consecutive cycles, no program start results. If it holds for GLITCH_W cycles or more, exactly one start results, even when the two strobes fall at different times.
- R7: `prog_start` is high for exactly one cycle per start, at most once per unbroken write combination.
- R8: A `mode_enter` pulse sets `prog_mode` on the next edge when the synchronized supply flag is high. It is ignored while that flag is low.
- R9: If `exit_pin_n` is held low for at least RST_EXIT_W cycles and then released, `prog_mode` clears. A shorter low pulse leaves `prog_mode` at 1.
- R10: A loss of `supply_ok` clears `prog_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all delays count its rising edges |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok | input | 1 | Supply comparator flag, 1 when the supply is above threshold (asynchronous) |
| ce_n | input | 1 | Flash chip select, active low (asynchronous) |
| oe_n | input | 1 | Flash output enable, active low (asynchronous) |
| we_n | input | 1 | Flash write enable, active low (asynchronous) |
| exit_pin_n | input | 1 | Dedicated active-low pin used to leave the programming mode (asynchronous) |
| mode_enter | input | 1 | Synchronous one-cycle request from the command decoder to enter the programming mode |
| prog_start | output | 1 | One-cycle program-cycle start request to the array |
| prog_mode | output | 1 | 1 while the special programming mode is active |
| supply_ready | output | 1 | 1 once the supply is good and the lockout delay has elapsed |

## Verification
Two kinds of internal fault are visible. A lockout counter that is not cleared by a short supply dip shows up as `supply_ready` returning early, before the full POR_DELAY+2 edges, on the first recovery after the dip. A glitch counter that does not restart shows up in the pulse count: `prog_start` appears after a sub-width strobe, or twice within one long write combination, and this is seen in the pulse count for that attempt within a few cycles. A wrong exit-pin counter leaves `prog_mode` wrong one edge after the pin is released. Because of that, each mode check is made a few cycles after the release.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_PROG   = 1'b1
  } mode_e;

  // bits needed to hold a count from 0 to n inclusive
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/guard_por.sv
module guard_por #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_s,
  output logic ready
);
  localparam int CW = guard_pkg::cnt_bits(DELAY);
  localparam logic [CW-1:0] FULL = CW'(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!vs_s) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      if (cnt != FULL) cnt <= cnt + 1'b1;
      ready <= (cnt >= LAST);
    end
  end
endmodule

// File: rtl/guard_strobe_filter.sv
module guard_strobe_filter #(
  parameter int GLITCH_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic ce_s,
  input  logic oe_s,
  input  logic we_s,
  output logic start
);
  localparam int CW = guard_pkg::cnt_bits(GLITCH_W);
  localparam logic [CW-1:0] FULL = CW'(GLITCH_W);
  localparam logic [CW-1:0] FIRE = CW'(GLITCH_W - 1);

  logic [CW-1:0] low_cnt;
  logic          wr_cond;
  logic          fire;

  assign wr_cond = !ce_s && !we_s && oe_s;
  assign fire    = wr_cond && ready && (low_cnt == FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      start   <= 1'b0;
    end else begin
      if (!wr_cond)             low_cnt <= '0;
      else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
      start <= fire;
    end
  end
endmodule

// File: rtl/guard_mode_ctl.sv
module guard_mode_ctl #(
  parameter int RST_EXIT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_s,
  input  logic rst_s,
  input  logic enter,
  output logic mode
);
  import guard_pkg::*;
  localparam int CW = cnt_bits(RST_EXIT_W);
  localparam logic [CW-1:0] FULL = CW'(RST_EXIT_W);

  logic [CW-1:0] low_cnt;
  logic          release_ok;
  mode_e         state;

  assign release_ok = rst_s && (low_cnt >= FULL);
  assign mode       = (state == MODE_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      state   <= MODE_NORMAL;
    end else begin
      if (rst_s)                low_cnt <= '0;
      else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
      if (!vs_s || release_ok) state <= MODE_NORMAL;
      else if (enter)          state <= MODE_PROG;
    end
  end
endmodule

// File: rtl/flash_prog_guard.sv
module flash_prog_guard #(
  parameter int SYNC_STAGES = 2,
  parameter int POR_DELAY   = 16,
  parameter int GLITCH_W    = 4,
  parameter int RST_EXIT_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic exit_pin_n,
  input  logic mode_enter,
  output logic prog_start,
  output logic prog_mode,
  output logic supply_ready
);
  localparam int NPIN = 5;
  // reset values: supply flag absent, all active-low pins inactive
  localparam logic [NPIN-1:0] PIN_RST = 5'b01111;

  logic [NPIN-1:0] pin_q;
  logic vs_s, rst_s, oe_s, we_s, ce_s;

  guard_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({supply_ok, exit_pin_n, oe_n, we_n, ce_n}),
    .q(pin_q)
  );
  assign {vs_s, rst_s, oe_s, we_s, ce_s} = pin_q;

  guard_por #(.DELAY(POR_DELAY)) u_por (
    .clk(clk), .rst_n(rst_n), .vs_s(vs_s), .ready(supply_ready)
  );

  guard_strobe_filter #(.GLITCH_W(GLITCH_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .ready(supply_ready),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .start(prog_start)
  );

  guard_mode_ctl #(.RST_EXIT_W(RST_EXIT_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .vs_s(vs_s), .rst_s(rst_s),
    .enter(mode_enter), .mode(prog_mode)
  );
endmodule

// File: rtl/guard_chk.sv
module guard_chk (
  input logic clk,
  input logic rst_n,
  input logic vs_s,
  input logic rst_s,
  input logic ce_s,
  input logic oe_s,
  input logic we_s,
  input logic mode_enter,
  input logic prog_start,
  input logic prog_mode,
  input logic supply_ready
);
  // R7
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  // R4
  start_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(supply_ready));

  // R5
  start_needs_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> ($past(oe_s) && !$past(ce_s) && !$past(we_s)));

  // R3
  ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_s |=> !supply_ready);

  // R8
  mode_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_mode) |-> ($past(mode_enter) && $past(vs_s)));

  // R9 and R10
  mode_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_mode) |-> (!$past(vs_s) || $past(rst_s)));
endmodule

bind flash_prog_guard guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vs_s(vs_s), .rst_s(rst_s),
  .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .mode_enter(mode_enter),
  .prog_start(prog_start), .prog_mode(prog_mode), .supply_ready(supply_ready)
);

// File: tb/test_flash_prog_guard.sv
module test_flash_prog_guard;
  localparam int CLK_PERIOD = 10;
  localparam int POR_D      = 16;
  localparam int GW         = 4;
  localparam int RW         = 8;

  logic clk = 1'b0;
  logic rst_n, supply_ok, ce_n, oe_n, we_n, exit_pin_n, mode_enter;
  logic prog_start, prog_mode, supply_ready;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct { string tag; int exp; } item_t;
  item_t sb_q[$];
  int    pulses = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_guard #(.SYNC_STAGES(2), .POR_DELAY(POR_D), .GLITCH_W(GW), .RST_EXIT_W(RW))
  i_flash_prog_guard (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .exit_pin_n(exit_pin_n), .mode_enter(mode_enter),
    .prog_start(prog_start), .prog_mode(prog_mode), .supply_ready(supply_ready)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: counts start pulses, checks width, settles scoreboard items
  logic prev_start = 1'b0;
  always @(negedge clk) begin
    if (prog_start === 1'b1) pulses++;
    if (prog_start === 1'b1 && prev_start === 1'b1) begin
      checks++; errors++;
      $display("FAIL R7 start width actual=2+ expected=1");
    end
    prev_start = prog_start;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (pulses != it.exp) begin
        errors++;
        $display("FAIL %s pulses actual=%0d expected=%0d", it.tag, pulses, it.exp);
      end
      pulses = 0;
    end
  end

  task automatic idle_strobes();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // drive one strobe pattern for w cycles, then expect `exp` start pulses
  task automatic strobe(int w, logic ce, logic we, logic oe, string tag, int exp);
    ce_n = ce; we_n = we; oe_n = oe;
    tick(w);
    idle_strobes();
    tick(8);
    sb_q.push_back('{tag, exp});
    tick(1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; idle_strobes();
    exit_pin_n = 1'b1; mode_enter = 1'b0;
    tick(3);
    check("R1 start in reset", prog_start, 1'b0);
    rst_n = 1'b1;
    tick(2);
    check("R1 mode after reset", prog_mode, 1'b0);
    check("R1 ready after reset", supply_ready, 1'b0);

    // R4: supply off, valid long write
    strobe(6, 1'b0, 1'b0, 1'b1, "R4 supply off", 0);

    // R2: exact lockout length
    supply_ok = 1'b1;
    tick(POR_D + 1);
    check("R2 ready still low", supply_ready, 1'b0);
    tick(1);
    check("R2 ready high", supply_ready, 1'b1);

    // R3: short dip restarts count from zero
    supply_ok = 1'b0;
    tick(4);
    check("R3 ready dropped", supply_ready, 1'b0);
    supply_ok = 1'b1;
    tick(10);
    supply_ok = 1'b0;
    tick(2);
    supply_ok = 1'b1;
    tick(POR_D + 1);
    check("R3 ready low after restart", supply_ready, 1'b0);
    tick(1);
    check("R3 ready high after full delay", supply_ready, 1'b1);

    // R4: write during lockout
    supply_ok = 1'b0;
    tick(4);
    supply_ok = 1'b1;
    strobe(6, 1'b0, 1'b0, 1'b1, "R4 lockout", 0);
    tick(10);
    check("R3 ready after recovery", supply_ready, 1'b1);

    // R6 / R7 glitch filter
    strobe(GW - 1, 1'b0, 1'b0, 1'b1, "R6 short pulse", 0);
    strobe(GW,     1'b0, 1'b0, 1'b1, "R6 min pulse", 1);
    strobe(12,     1'b0, 1'b0, 1'b1, "R7 long pulse one start", 1);
    // R5 static inhibits
    strobe(10, 1'b0, 1'b0, 1'b0, "R5 oe low", 0);
    strobe(10, 1'b1, 1'b0, 1'b1, "R5 ce high", 0);
    strobe(10, 1'b0, 1'b1, 1'b1, "R5 we high", 0);
    // R6 staggered strobes: overlap exactly GW
    ce_n = 1'b0; tick(3);
    we_n = 1'b0; tick(GW);
    we_n = 1'b1; tick(2);
    idle_strobes(); tick(8);
    sb_q.push_back('{"R6 staggered overlap", 1});
    tick(1);
    // R6 staggered with too-short overlap
    ce_n = 1'b0; tick(3);
    we_n = 1'b0; tick(GW - 1);
    we_n = 1'b1; tick(2);
    idle_strobes(); tick(8);
    sb_q.push_back('{"R6 staggered short overlap", 0});
    tick(1);

    // R8 mode entry
    mode_enter = 1'b1; tick(1); mode_enter = 1'b0;
    check("R8 mode set", prog_mode, 1'b1);
    // R9 short exit pulse ignored
    exit_pin_n = 1'b0; tick(RW - 3); exit_pin_n = 1'b1;
    tick(6);
    check("R9 short exit pulse keeps mode", prog_mode, 1'b1);
    // R9 long enough exit pulse
    exit_pin_n = 1'b0; tick(RW); exit_pin_n = 1'b1;
    tick(6);
    check("R9 exit pulse clears mode", prog_mode, 1'b0);
    // R10 supply loss clears mode
    mode_enter = 1'b1; tick(1); mode_enter = 1'b0;
    check("R8 mode set again", prog_mode, 1'b1);
    supply_ok = 1'b0;
    tick(4);
    check("R10 supply loss clears mode", prog_mode, 1'b0);
    // R8 entry ignored with supply low
    mode_enter = 1'b1; tick(1); mode_enter = 1'b0;
    tick(1);
    check("R8 entry ignored without supply", prog_mode, 1'b0);

    tick(4);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
    end
    finish_run();
  end
endmodule